// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the protocol engine of an I2C target (slave) that answers to a 7-bit bus address. A master uses it to read and write a small byte-wide register space through an 8-bit register pointer. The block takes SCL and SDA levels that are already synchronized and filtered, plus one-cycle start and stop strobes from the pad-side condition detector. It returns a single open-drain pull-down enable for SDA, and it presents a plain register port to a neighbouring register file: the address, the write data, a one-cycle write strobe, the read data coming back, and a flag that says whether the pointer hits an implemented register.

A write transfer loads the pointer with its first data byte. Each further data byte is stored at the pointer. A read transfer returns bytes starting at the pointer, so the master can read from the current address, or it can write the pointer and then issue a repeated start to make a random read. Reads and writes both continue across consecutive addresses. The pointer steps after every data byte, whether or not the address it holds is implemented, and it wraps at the top of its range. The acknowledge bit tells the master whether each pointer value it reaches is usable.

The block never holds SCL low. It has no general-call response, no 10-bit addressing and no identification read.

Top module: `i2c_ptr_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 101011 followed by the strap input `addr_sel_i`, so 56h with the strap low and 57h with the strap high. Bit 0 of that byte is the direction: 0 means write and 1 means read. Any other address, including the all-zero general call, gets no acknowledge, and the target then stays silent until the next start.
- R2: Bytes travel most significant bit first. When the target acknowledges, it pulls SDA low from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock. The target never changes its SDA drive while SCL stays high.
- R3: In a write transfer, the first byte after the address loads the pointer. The target acknowledges that byte only if the new pointer is implemented, meaning 00h to 07h or 0Bh.
- R4: After the pointer byte, a written byte is stored and acknowledged only when the pointer is writable (02h to 07h or 0Bh). At 00h and 01h, which are read-only, and at any unimplemented address, the byte is discarded and not acknowledged.
- R5: The pointer steps by one after every data byte, whether written or read and whether the address is valid or not. It wraps from FFh to 00h. Acknowledges resume as soon as the pointer reaches a valid register again.
- R6: A read at an unimplemented address returns 00h, whatever the register file supplies, and still advances the pointer.
- R7: A read transfer that is not preceded by a pointer write starts at the pointer value left by the previous transfer.
- R8: In a read, the target sends another byte after each master acknowledge. After a master not-acknowledge it leaves SDA released, so the master can issue a stop.
- R9: A repeated start after a pointer write begins a new address phase without a stop, so a pointer-write-then-read sequence works.
- R10: A start or stop that arrives in the middle of a byte abandons that byte: nothing is stored, the pointer keeps its value, and SDA is released.
- R11: After reset the pointer is 00h and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered, synchronized SCL level |
| sda_i | input | 1 | Filtered, synchronized SDA level |
| start_i | input | 1 | One-cycle strobe for a start or repeated start |
| stop_i | input | 1 | One-cycle strobe for a stop |
| addr_sel_i | input | 1 | Static strap that sets bit 0 of the bus address |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| reg_addr_o | output | ADDR_W | Register pointer presented to the register file |
| reg_wdata_o | output | 8 | Byte to be written |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register file read data at `reg_addr_o` |
| reg_hit_o | output | 1 | The pointer addresses an implemented register |

## Verification
The bench aims at the places where the pointer and the acknowledge rules disagree. It writes through the read-only and unimplemented addresses and back into 0Bh. A design that gated the pointer step on validity would then land on the wrong register, and one that acknowledged every byte would store data at the read-only registers. The bench reads at FFh and across the wrap to 00h, where a design that failed to wrap, or that forwarded the register file's data at an unimplemented address, returns bytes that are not 00h or the first register. It also cuts a write short with a stop halfway through a byte and makes a current-address read straight after a random read. A design that committed partial bytes, or that reset the pointer between transfers, changes a register or starts at the wrong place.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_PTR,
      ST_WDATA,
      ST_RDATA,
      ST_MACK
   } tgt_state_t;

endpackage

// File: rtl/i2c_ptr_edge.sv
module i2c_ptr_edge #(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= IDLE_LVL;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
   assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/i2c_ptr_decode.sv
module i2c_ptr_decode #(
   parameter int ADDR_W     = 8,
   parameter int LIN_LAST   = 7,
   parameter bit HAS_EXTRA  = 1'b1,
   parameter int EXTRA_ADDR = 11
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   logic lin_hit;
   logic extra_hit;

   assign lin_hit = int'(addr_i) <= LIN_LAST;

   generate
      if (HAS_EXTRA) begin : g_extra
         assign extra_hit = int'(addr_i) == EXTRA_ADDR;
      end else begin : g_no_extra
         assign extra_hit = 1'b0;
      end
   endgenerate

   assign hit_o = lin_hit | extra_hit;

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
   import i2c_ptr_pkg::*;
#(
   parameter int           ADDR_W      = 8,
   parameter logic [5:0]   DEV_ADDR_HI = 6'b101011,
   parameter int           LIN_LAST    = 7,
   parameter int           RO_LAST     = 1,
   parameter bit           HAS_EXTRA   = 1'b1,
   parameter int           EXTRA_ADDR  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              addr_sel_i,
   output logic              sda_pull_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic [7:0]        reg_wdata_o,
   output logic              reg_wr_o,
   input  logic [7:0]        reg_rdata_i,
   output logic              reg_hit_o
);

   localparam int MAX_PTR = (1 << ADDR_W) - 1;
   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_aw
         $error("ADDR_W must lie between 1 and the byte width");
      end
      if (LIN_LAST < 0 || LIN_LAST > MAX_PTR) begin : g_bad_lin
         $error("LIN_LAST outside the pointer range");
      end
      if (RO_LAST > LIN_LAST) begin : g_bad_ro
         $error("RO_LAST must not exceed LIN_LAST");
      end
      if (HAS_EXTRA && (EXTRA_ADDR <= LIN_LAST || EXTRA_ADDR > MAX_PTR)) begin : g_bad_extra
         $error("EXTRA_ADDR must lie above the linear range and inside the pointer range");
      end
   endgenerate

   tgt_state_t         state;
   logic [BIT_CNT_W-1:0] cnt;
   logic [BYTE_W-1:0]  shreg;
   logic [ADDR_W-1:0]  ptr;
   logic               drive;
   logic               in_ack;
   logic               rw;

   logic scl_rise, scl_fall;
   logic ptr_hit, rx_hit, ptr_wr_ok;
   logic dev_match;
   logic [BYTE_W-1:0] tx_byte;
   logic byte_end, quiet;
   logic ptr_load;

   i2c_ptr_edge #(.IDLE_LVL(1'b1)) u_scl_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (scl_i),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   i2c_ptr_decode #(
      .ADDR_W(ADDR_W), .LIN_LAST(LIN_LAST),
      .HAS_EXTRA(HAS_EXTRA), .EXTRA_ADDR(EXTRA_ADDR)
   ) u_dec_ptr (
      .addr_i (ptr),
      .hit_o  (ptr_hit)
   );

   i2c_ptr_decode #(
      .ADDR_W(ADDR_W), .LIN_LAST(LIN_LAST),
      .HAS_EXTRA(HAS_EXTRA), .EXTRA_ADDR(EXTRA_ADDR)
   ) u_dec_rx (
      .addr_i (shreg[ADDR_W-1:0]),
      .hit_o  (rx_hit)
   );

   assign ptr_wr_ok = ptr_hit && (int'(ptr) > RO_LAST);
   assign dev_match = (shreg[7:1] == {DEV_ADDR_HI, addr_sel_i});
   assign tx_byte   = ptr_hit ? reg_rdata_i : '0;
   assign quiet     = !start_i && !stop_i;
   assign byte_end  = quiet && !in_ack && scl_fall && (cnt == LAST_BIT);
   assign ptr_load  = byte_end && (state == ST_PTR);

   assign reg_wr_o    = byte_end && (state == ST_WDATA) && ptr_wr_ok;
   assign reg_addr_o  = ptr;
   assign reg_wdata_o = shreg;
   assign reg_hit_o   = ptr_hit;
   assign sda_pull_o  = drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         shreg  <= '0;
         ptr    <= '0;
         drive  <= 1'b0;
         in_ack <= 1'b0;
         rw     <= 1'b0;
      end else if (start_i) begin
         state  <= ST_DEVADR;
         cnt    <= '0;
         in_ack <= 1'b0;
         drive  <= 1'b0;
      end else if (stop_i) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         in_ack <= 1'b0;
         drive  <= 1'b0;
      end else begin
         unique case (state)
            ST_DEVADR, ST_PTR, ST_WDATA: begin
               if (in_ack) begin
                  if (scl_fall) begin
                     in_ack <= 1'b0;
                     drive  <= 1'b0;
                     if (state == ST_DEVADR) begin
                        if (rw) begin
                           state <= ST_RDATA;
                           shreg <= tx_byte;
                           drive <= ~tx_byte[BYTE_W-1];
                           cnt   <= '0;
                        end else begin
                           state <= ST_PTR;
                        end
                     end else if (state == ST_PTR) begin
                        state <= ST_WDATA;
                     end
                  end
               end else if (scl_rise && cnt != LAST_BIT) begin
                  shreg <= {shreg[BYTE_W-2:0], sda_i};
                  cnt   <= cnt + 1'b1;
               end else if (scl_fall && cnt == LAST_BIT) begin
                  cnt <= '0;
                  if (state == ST_DEVADR) begin
                     if (dev_match) begin
                        in_ack <= 1'b1;
                        drive  <= 1'b1;
                        rw     <= shreg[0];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_PTR) begin
                     ptr    <= shreg[ADDR_W-1:0];
                     in_ack <= 1'b1;
                     drive  <= rx_hit;
                  end else begin
                     ptr    <= ptr + 1'b1;
                     in_ack <= 1'b1;
                     drive  <= ptr_wr_ok;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise && cnt != LAST_BIT) begin
                  cnt <= cnt + 1'b1;
               end else if (scl_fall && cnt != '0) begin
                  if (cnt == LAST_BIT) begin
                     drive <= 1'b0;
                     state <= ST_MACK;
                     ptr   <= ptr + 1'b1;
                     cnt   <= '0;
                  end else begin
                     shreg <= {shreg[BYTE_W-2:0], 1'b0};
                     drive <= ~shreg[BYTE_W-2];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  if (sda_i) state <= ST_IDLE;
                  else       cnt   <= 4'd1;
               end else if (scl_fall && cnt == 4'd1) begin
                  state <= ST_RDATA;
                  shreg <= tx_byte;
                  drive <= ~tx_byte[BYTE_W-1];
                  cnt   <= '0;
               end
            end
            default: ;
         endcase
      end
   end

   // R2: the SDA drive never moves while SCL is high
   a_r2_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(sda_pull_o));

   // R4: writes reach the register file only at writable, implemented addresses
   a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (reg_hit_o && int'(reg_addr_o) > RO_LAST));

   // R5: the pointer either steps by one or is loaded by a pointer byte
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_o != $past(reg_addr_o)) |->
      ((reg_addr_o == ADDR_W'($past(reg_addr_o) + 1'b1)) || $past(ptr_load)));

   // R10: a start releases SDA on the next cycle
   a_r10_start_release: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !sda_pull_o);

   // R8: a master not-acknowledge leaves SDA released
   a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MACK && scl_rise && sda_i && quiet) |=> (!sda_pull_o && state == ST_IDLE));

endmodule

// File: tb/i2c_ptr_target_tb.sv
module i2c_ptr_target_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int Q = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic start_s = 1'b0;
   logic stop_s = 1'b0;
   logic strap = 1'b0;
   logic sda_pull;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic reg_wr;
   logic [7:0] reg_rdata;
   logic reg_hit;
   logic sda_bus;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] rf [0:255];
   logic [7:0] exp_rf [0:255];
   logic [7:0] m_ptr;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus   = sda_m & ~sda_pull;
   assign reg_rdata = rf[reg_addr];

   always_ff @(posedge clk) begin
      if (reg_wr) rf[reg_addr] <= reg_wdata;
   end

   i2c_ptr_target dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .start_i     (start_s),
      .stop_i      (stop_s),
      .addr_sel_i  (strap),
      .sda_pull_o  (sda_pull),
      .reg_addr_o  (reg_addr),
      .reg_wdata_o (reg_wdata),
      .reg_wr_o    (reg_wr),
      .reg_rdata_i (reg_rdata),
      .reg_hit_o   (reg_hit)
   );

   function automatic bit m_valid(input logic [7:0] a);
      return (a <= 8'h07) || (a == 8'h0B);
   endfunction

   function automatic bit m_wr(input logic [7:0] a);
      return m_valid(a) && (a >= 8'h02);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q(Q);
      scl = 1'b1;   wait_q(Q);
      sda_m = 1'b0; start_s = 1'b1; wait_q(1);
      start_s = 1'b0; wait_q(Q);
      scl = 1'b0;   wait_q(Q);
   endtask

   task automatic bus_stop();
      scl = 1'b0;   wait_q(Q);
      sda_m = 1'b0; wait_q(Q);
      scl = 1'b1;   wait_q(Q);
      sda_m = 1'b1; stop_s = 1'b1; wait_q(1);
      stop_s = 1'b0; wait_q(Q);
   endtask

   task automatic send_bit(input logic b, output logic s);
      sda_m = b; wait_q(Q);
      scl = 1'b1; wait_q(Q);
      s = sda_bus; wait_q(Q);
      scl = 1'b0; wait_q(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) send_bit(b[i], s);
      send_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         send_bit(1'b1, s);
         d[i] = s;
      end
      send_bit(~mack, s);
   endtask

   task automatic dev_phase(input logic rd, input string req);
      logic ack;
      wr_byte({6'b101011, strap, rd}, ack);
      chk(req, {7'd0, ack}, 8'd1);
   endtask

   task automatic set_ptr(input logic [7:0] p, input string req);
      logic ack;
      bus_start();
      dev_phase(1'b0, "R1 address ack");
      wr_byte(p, ack);
      chk(req, {7'd0, ack}, {7'd0, m_valid(p)});
      m_ptr = p;
   endtask

   task automatic m_write(input logic [7:0] b, input string req);
      logic ack;
      wr_byte(b, ack);
      chk(req, {7'd0, ack}, {7'd0, m_wr(m_ptr)});
      if (m_wr(m_ptr)) exp_rf[m_ptr] = b;
      m_ptr = m_ptr + 8'd1;
   endtask

   task automatic m_read(input logic mack, input string req);
      logic [7:0] d;
      rd_byte(mack, d);
      chk(req, d, m_valid(m_ptr) ? exp_rf[m_ptr] : 8'h00);
      m_ptr = m_ptr + 8'd1;
   endtask

   task automatic t_reset();
      chk("R11 sda released", {7'd0, sda_pull}, 8'd0);
      chk("R11 pointer zero", reg_addr, 8'h00);
      m_ptr = 8'h00;
      bus_start();
      dev_phase(1'b1, "R1 read address ack");
      m_read(1'b1, "R7 current read from reset pointer");
      m_read(1'b0, "R2 msb-first second byte");
      bus_stop();
   endtask

   task automatic t_address();
      logic ack;
      bus_start();
      wr_byte({7'h57, 1'b0}, ack);
      chk("R1 other strap address ignored", {7'd0, ack}, 8'd0);
      bus_stop();
      bus_start();
      wr_byte(8'h00, ack);
      chk("R1 general call ignored", {7'd0, ack}, 8'd0);
      wr_byte(8'h05, ack);
      chk("R1 silent after mismatch", {7'd0, ack}, 8'd0);
      bus_stop();
      strap = 1'b1;
      bus_start();
      dev_phase(1'b0, "R1 strap high answers 57h");
      bus_stop();
      bus_start();
      wr_byte({7'h56, 1'b0}, ack);
      chk("R1 56h ignored with strap high", {7'd0, ack}, 8'd0);
      bus_stop();
      strap = 1'b0;
   endtask

   task automatic t_page_random();
      set_ptr(8'h02, "R3 valid pointer ack");
      m_write(8'h11, "R4 page write");
      m_write(8'h22, "R4 page write");
      m_write(8'h33, "R4 page write");
      m_write(8'h44, "R4 page write");
      bus_stop();
      set_ptr(8'h02, "R3 valid pointer ack");
      bus_start();
      dev_phase(1'b1, "R9 repeated start address");
      m_read(1'b1, "R9 random read");
      m_read(1'b1, "R8 sequential read");
      m_read(1'b0, "R8 last read");
      wait_q(2);
      chk("R8 sda released after nack", {7'd0, sda_bus}, 8'd1);
      bus_stop();
      bus_start();
      dev_phase(1'b1, "R7 read address");
      m_read(1'b0, "R7 current address continues");
      bus_stop();
   endtask

   task automatic t_invalid();
      set_ptr(8'h08, "R3 invalid pointer nack");
      m_write(8'h5A, "R4 invalid write nack");
      m_write(8'h5B, "R4 invalid write nack");
      m_write(8'h5C, "R4 invalid write nack");
      m_write(8'h6D, "R5 ack resumes at 0Bh");
      bus_stop();
      set_ptr(8'h0A, "R3 invalid pointer nack");
      bus_start();
      dev_phase(1'b1, "R9 repeated start address");
      m_read(1'b1, "R6 invalid read zero");
      m_read(1'b1, "R5 valid after invalid");
      m_read(1'b0, "R6 invalid read zero");
      bus_stop();
   endtask

   task automatic t_readonly_wrap();
      set_ptr(8'h00, "R3 read-only pointer ack");
      m_write(8'hFF, "R4 read-only write nack");
      m_write(8'hEE, "R4 read-only write nack");
      m_write(8'h77, "R5 ack resumes at 02h");
      bus_stop();
      set_ptr(8'hFF, "R3 top pointer nack");
      bus_start();
      dev_phase(1'b1, "R9 repeated start address");
      m_read(1'b1, "R6 read at FFh zero");
      m_read(1'b1, "R5 wrap to 00h");
      m_read(1'b1, "R4 read-only unchanged");
      m_read(1'b0, "R4 register 02h written");
      bus_stop();
   endtask

   task automatic t_abort();
      logic s;
      set_ptr(8'h03, "R3 valid pointer ack");
      for (int i = 0; i < 4; i++) send_bit(1'b0, s);
      bus_stop();
      chk("R10 pointer held after abort", reg_addr, 8'h03);
      chk("R10 sda released after abort", {7'd0, sda_pull}, 8'd0);
      set_ptr(8'h03, "R3 valid pointer ack");
      bus_start();
      dev_phase(1'b1, "R9 repeated start address");
      m_read(1'b0, "R10 register unchanged");
      bus_stop();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         rf[i] = 8'hEE;
         exp_rf[i] = 8'hEE;
      end
      for (int i = 2; i < 8; i++) begin
         rf[i] = 8'h00;
         exp_rf[i] = 8'h00;
      end
      rf[11] = 8'h00; exp_rf[11] = 8'h00;
      rf[0] = 8'hA5;  exp_rf[0] = 8'hA5;
      rf[1] = 8'h3C;  exp_rf[1] = 8'h3C;
      wait_q(5);
      rst_n = 1'b1;
      wait_q(5);
      t_reset();
      t_address();
      t_page_random();
      t_invalid();
      t_readonly_wrap();
      t_abort();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule